// File: doc/BRIEF.md
# Two-Bank Maskable Interrupt Controller

This block collects 64 level-sensitive peripheral interrupt lines and 8 level-sensitive local interrupt lines and turns them into two interrupt outputs for a processor. The normal output is raised whenever any line is high and its enable bit is set. The fast output follows one line chosen by software. It takes that line's raw level and does not look at the enable masks. Pending state is never latched: a pending bit is the current line level ANDed with its enable bit.

Software reaches the block through a plain 32-bit register port. An address and a write strobe apply write data at the clock edge. Read data is presented combinationally for the address on the port. Enable masks are never written directly. A set register ORs ones into a mask, and a clear register removes the bits written as one, so separate agents can change different bits without a read-modify-write. A summary register brings together the masked local lines, one "anything pending" flag per 32-line peripheral bank, and mirrored copies of eleven chosen peripheral lines, so a handler can often decide what to service from one read.

Top module: `irq_fanin_ctrl`

## Requirements
- R1: After reset both enable masks are zero, the fast-path enable and source select are zero, and both outputs are 0.
- R2: A write to the set register at 0x10 (peripheral lines 31:0), 0x14 (lines 63:32) or 0x18 (local lines, data bits 7:0 only) ORs the written ones into that mask and leaves every other mask bit unchanged.
- R3: A write to the clear register at 0x1C (lines 31:0), 0x20 (lines 63:32) or 0x24 (local lines, data bits 7:0 only) clears each mask bit written as 1 and leaves the others unchanged.
- R4: A read of a set register returns its mask (the local mask zero-extended to 32 bits). A read of a clear register returns the 32-bit bitwise inverse of that value, so the upper 24 bits of 0x24 read as ones.
- R5: A read of 0x04 returns peripheral levels 31:0 ANDed with their enable bits, and 0x08 returns the same for lines 63:32. A line that drops reads 0 at once, with no latching.
- R6: In the summary register at 0x00, bits 7:0 hold the masked local lines. Bit 8 is set when any masked peripheral line 0 to 31 is pending, and bit 9 when any masked line 32 to 63 is pending.
- R7: Summary bits 10 to 20 hold the masked pending state of peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, bit 10 carrying line 7 and so on in that order. Bits 31:21 read 0.
- R8: The fast control register at 0x0C takes the source select in bits 6:0 and the enable in bit 7, and reads back the same fields with bits 31:8 zero. Select values 0 to 63 name peripheral line n, and 64 to 71 name local line n-64.
- R9: The fast output is the raw level of the selected line whatever the masks hold. It is 0 when the enable bit is 0 or when the select value is 72 or more.
- R10: The normal output is 1 exactly when some line in either group is high with its enable bit set.
- R11: Both outputs are registered: an input level change before a clock edge shows at the outputs after that edge, and a register write takes effect on the mask at its edge and at the outputs one edge later.
- R12: Reads of unmapped offsets return 0. Writes to unmapped offsets or to the read-only offsets 0x00, 0x04 and 0x08 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, applied at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| periph_i | input | 64 | Peripheral interrupt levels |
| local_i | input | 8 | Local interrupt levels |
| irq_o | output | 1 | Normal interrupt output, registered |
| fiq_o | output | 1 | Fast interrupt output, registered |

## Verification
The bench walks a single line across all eleven mirrored positions. A design with an off-by-one or reordered mirror list would set the wrong summary bit, and one that mirrored unmasked levels would flag lines that are not enabled. It sets the fast path on a local line whose mask bit is clear, then on select values 72 and above. A design that gated the fast path with the mask, or that wrapped the select index, would raise or drop fiq_o wrongly. It writes the local set and clear registers with junk in the upper bits and reads the clear registers back. A design that kept more than eight local bits, or that inverted only the low byte, would show the wrong value. It also drops a line after enabling it, to catch a pending bit that latches, and it times both outputs to the edge, to catch an extra or missing pipeline stage.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int PERIPH_LINES = 64;
    localparam int LOCAL_LINES  = 8;
    localparam int WORD_W       = 32;
    localparam int ADDR_W       = 8;
    localparam int SEL_W        = 7;
    localparam int MIRROR_COUNT = 11;
    localparam int MIRROR_BASE  = 10;

    typedef enum logic [3:0] {
        REG_SUMMARY,
        REG_PEND_LO,
        REG_PEND_HI,
        REG_FAST_CTL,
        REG_SET_LO,
        REG_SET_HI,
        REG_SET_LOC,
        REG_CLR_LO,
        REG_CLR_HI,
        REG_CLR_LOC,
        REG_NONE
    } reg_sel_e;

    // Offset decode shared by the read mux and the write path.
    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] off);
        case (off)
            ADDR_W'(8'h00): return REG_SUMMARY;
            ADDR_W'(8'h04): return REG_PEND_LO;
            ADDR_W'(8'h08): return REG_PEND_HI;
            ADDR_W'(8'h0C): return REG_FAST_CTL;
            ADDR_W'(8'h10): return REG_SET_LO;
            ADDR_W'(8'h14): return REG_SET_HI;
            ADDR_W'(8'h18): return REG_SET_LOC;
            ADDR_W'(8'h1C): return REG_CLR_LO;
            ADDR_W'(8'h20): return REG_CLR_HI;
            ADDR_W'(8'h24): return REG_CLR_LOC;
            default:        return REG_NONE;
        endcase
    endfunction

    // Peripheral line copied into summary bit MIRROR_BASE + idx.
    function automatic int mirror_line(input int idx);
        case (idx)
            0:       return 7;
            1:       return 9;
            2:       return 10;
            3:       return 18;
            4:       return 19;
            5:       return 53;
            6:       return 54;
            7:       return 55;
            8:       return 56;
            9:       return 57;
            default: return 62;
        endcase
    endfunction

endpackage

// File: rtl/irqc_mask_regs.sv
module irqc_mask_regs
    import irqc_pkg::*;
#(
    parameter int PL = PERIPH_LINES,
    parameter int LL = LOCAL_LINES,
    parameter int WW = WORD_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  reg_sel_e      wr_sel,
    input  logic [WW-1:0] wr_data,
    output logic [PL-1:0] pmask_o,
    output logic [LL-1:0] lmask_o,
    output logic          fast_en_o,
    output logic [SW-1:0] fast_sel_o
);

    typedef struct packed {
        logic [PL-1:0] pmask;
        logic [LL-1:0] lmask;
        logic          fen;
        logic [SW-1:0] fsel;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (wr_sel)
            REG_SET_LO:   st_d.pmask[0 +: WW]  = st_q.pmask[0 +: WW]  | wr_data;
            REG_SET_HI:   st_d.pmask[WW +: WW] = st_q.pmask[WW +: WW] | wr_data;
            REG_SET_LOC:  st_d.lmask = st_q.lmask | wr_data[LL-1:0];
            REG_CLR_LO:   st_d.pmask[0 +: WW]  = st_q.pmask[0 +: WW]  & ~wr_data;
            REG_CLR_HI:   st_d.pmask[WW +: WW] = st_q.pmask[WW +: WW] & ~wr_data;
            REG_CLR_LOC:  st_d.lmask = st_q.lmask & ~wr_data[LL-1:0];
            REG_FAST_CTL: begin
                st_d.fsel = wr_data[SW-1:0];
                st_d.fen  = wr_data[SW];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pmask_o    = st_q.pmask;
    assign lmask_o    = st_q.lmask;
    assign fast_en_o  = st_q.fen;
    assign fast_sel_o = st_q.fsel;

endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
    import irqc_pkg::*;
#(
    parameter int PL = PERIPH_LINES,
    parameter int LL = LOCAL_LINES,
    parameter int WW = WORD_W
) (
    input  logic [PL-1:0] periph_i,
    input  logic [LL-1:0] local_i,
    input  logic [PL-1:0] pmask_i,
    input  logic [LL-1:0] lmask_i,
    output logic [PL-1:0] pend_p_o,
    output logic [LL-1:0] pend_l_o,
    output logic [WW-1:0] summary_o,
    output logic          any_o
);

    localparam int BANKS = PL / WW;

    logic [BANKS-1:0] bank_hit;

    assign pend_p_o = periph_i & pmask_i;
    assign pend_l_o = local_i & lmask_i;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign bank_hit[b] = |pend_p_o[b*WW +: WW];
    end

    always_comb begin
        summary_o = '0;
        summary_o[LL-1:0] = pend_l_o;
        for (int b = 0; b < BANKS; b++) begin
            summary_o[LL + b] = bank_hit[b];
        end
        for (int i = 0; i < MIRROR_COUNT; i++) begin
            summary_o[MIRROR_BASE + i] = pend_p_o[mirror_line(i)];
        end
    end

    assign any_o = (|bank_hit) | (|pend_l_o);

endmodule

// File: rtl/irqc_fast_pick.sv
module irqc_fast_pick
    import irqc_pkg::*;
#(
    parameter int PL = PERIPH_LINES,
    parameter int LL = LOCAL_LINES,
    parameter int SW = SEL_W
) (
    input  logic [PL-1:0] periph_i,
    input  logic [LL-1:0] local_i,
    input  logic          en_i,
    input  logic [SW-1:0] sel_i,
    output logic          pick_o
);

    localparam int PIDX_W = $clog2(PL);
    localparam int LIDX_W = $clog2(LL);

    always_comb begin
        pick_o = 1'b0;
        if (en_i) begin
            if (sel_i < SW'(PL)) begin
                pick_o = periph_i[sel_i[PIDX_W-1:0]];
            end else if (sel_i < SW'(PL + LL)) begin
                pick_o = local_i[LIDX_W'(sel_i - SW'(PL))];
            end
        end
    end

endmodule

// File: rtl/irqc_out_stage.sv
module irqc_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic any_i,
    input  logic pick_i,
    output logic irq_o,
    output logic fiq_o
);

    typedef struct packed {
        logic irq;
        logic fiq;
    } outs_t;

    outs_t out_d, out_q;

    always_comb begin
        out_d.irq = any_i;
        out_d.fiq = pick_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_o = out_q.irq;
    assign fiq_o = out_q.fiq;

endmodule

// File: rtl/irq_fanin_ctrl.sv
module irq_fanin_ctrl
    import irqc_pkg::*;
#(
    parameter int PL = PERIPH_LINES,
    parameter int LL = LOCAL_LINES,
    parameter int WW = WORD_W,
    parameter int AW = ADDR_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [WW-1:0] bus_wdata,
    output logic [WW-1:0] bus_rdata,
    input  logic [PL-1:0] periph_i,
    input  logic [LL-1:0] local_i,
    output logic          irq_o,
    output logic          fiq_o
);

    reg_sel_e      rd_sel;
    reg_sel_e      wr_sel;
    logic [PL-1:0] pmask_w;
    logic [LL-1:0] lmask_w;
    logic          fast_en_w;
    logic [SW-1:0] fast_sel_w;
    logic [PL-1:0] pend_p_w;
    logic [LL-1:0] pend_l_w;
    logic [WW-1:0] summary_w;
    logic          any_w;
    logic          pick_w;

    assign rd_sel = decode_offset(bus_addr);
    assign wr_sel = bus_wr ? rd_sel : REG_NONE;

    irqc_mask_regs #(.PL(PL), .LL(LL), .WW(WW), .SW(SW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sel     (wr_sel),
        .wr_data    (bus_wdata),
        .pmask_o    (pmask_w),
        .lmask_o    (lmask_w),
        .fast_en_o  (fast_en_w),
        .fast_sel_o (fast_sel_w)
    );

    irqc_pending #(.PL(PL), .LL(LL), .WW(WW)) u_pend (
        .periph_i  (periph_i),
        .local_i   (local_i),
        .pmask_i   (pmask_w),
        .lmask_i   (lmask_w),
        .pend_p_o  (pend_p_w),
        .pend_l_o  (pend_l_w),
        .summary_o (summary_w),
        .any_o     (any_w)
    );

    irqc_fast_pick #(.PL(PL), .LL(LL), .SW(SW)) u_fast (
        .periph_i (periph_i),
        .local_i  (local_i),
        .en_i     (fast_en_w),
        .sel_i    (fast_sel_w),
        .pick_o   (pick_w)
    );

    irqc_out_stage u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .any_i  (any_w),
        .pick_i (pick_w),
        .irq_o  (irq_o),
        .fiq_o  (fiq_o)
    );

    // Read mux: local values widen to a word, clear views are full inversions.
    always_comb begin
        unique case (rd_sel)
            REG_SUMMARY:  bus_rdata = summary_w;
            REG_PEND_LO:  bus_rdata = pend_p_w[0 +: WW];
            REG_PEND_HI:  bus_rdata = pend_p_w[WW +: WW];
            REG_FAST_CTL: bus_rdata = WW'({fast_en_w, fast_sel_w});
            REG_SET_LO:   bus_rdata = pmask_w[0 +: WW];
            REG_SET_HI:   bus_rdata = pmask_w[WW +: WW];
            REG_SET_LOC:  bus_rdata = WW'(lmask_w);
            REG_CLR_LO:   bus_rdata = ~pmask_w[0 +: WW];
            REG_CLR_HI:   bus_rdata = ~pmask_w[WW +: WW];
            REG_CLR_LOC:  bus_rdata = ~(WW'(lmask_w));
            default:      bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int PL = PERIPH_LINES,
    parameter int LL = LOCAL_LINES,
    parameter int WW = WORD_W,
    parameter int AW = ADDR_W,
    parameter int SW = SEL_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic [WW-1:0] bus_wdata,
    input logic [PL-1:0] periph_i,
    input logic [LL-1:0] local_i,
    input logic [PL-1:0] pmask,
    input logic [LL-1:0] lmask,
    input logic          fast_en,
    input logic [SW-1:0] fast_sel,
    input logic          irq_o,
    input logic          fiq_o
);

    localparam int PIDX_W = $clog2(PL);

    AST_IRQ_FOLLOWS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past((|(periph_i & pmask)) || (|(local_i & lmask)))); // R10

    AST_FAST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fast_en) |-> !fiq_o); // R9

    AST_FAST_RANGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fast_en) && ($past(fast_sel) >= SW'(PL + LL))) |-> !fiq_o); // R9

    AST_FAST_PERIPH_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fast_en) && ($past(fast_sel) < SW'(PL)))
        |-> (fiq_o == $past(periph_i[fast_sel[PIDX_W-1:0]]))); // R9

    AST_SET_LOW_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(8'h10))
        |=> ((pmask[WW-1:0] & $past(bus_wdata)) == $past(bus_wdata))); // R2

    AST_CLR_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(8'h1C))
        |=> ((pmask[WW-1:0] & $past(bus_wdata)) == '0)); // R3

    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(pmask) && $stable(lmask)
                     && $stable(fast_en) && $stable(fast_sel))); // R12

    AST_READ_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == AW'(8'h00) || bus_addr == AW'(8'h04)
                    || bus_addr == AW'(8'h08)))
        |=> ($stable(pmask) && $stable(lmask)
             && $stable(fast_en) && $stable(fast_sel))); // R12

endmodule

bind irq_fanin_ctrl irqc_checker #(
    .PL(PL), .LL(LL), .WW(WW), .AW(AW), .SW(SW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .periph_i  (periph_i),
    .local_i   (local_i),
    .pmask     (pmask_w),
    .lmask     (lmask_w),
    .fast_en   (fast_en_w),
    .fast_sel  (fast_sel_w),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
);

// File: tb/sim_irq_fanin_ctrl.sv
`timescale 1ns/1ps
module sim_irq_fanin_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        fiq_o;

    // Bench-side model of the register state and the line levels.
    logic [63:0] pl = '0;
    logic [7:0]  ll = '0;
    logic [63:0] pm = '0;
    logic [7:0]  lm = '0;
    logic        fe = 1'b0;
    logic [6:0]  fs = '0;

    always #4 clk = ~clk;

    irq_fanin_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .periph_i  (pl),
        .local_i   (ll),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    typedef struct {
        int          kind;   // 0 read data, 1 irq_o, 2 fiq_o
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    int mirror_list [11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};

    function automatic logic [31:0] exp_reg(input logic [7:0] a);
        logic [63:0] pp;
        logic [31:0] r;
        pp = pl & pm;
        r  = '0;
        case (a)
            8'h00: begin
                r[7:0] = ll & lm;
                r[8]   = |pp[31:0];
                r[9]   = |pp[63:32];
                for (int i = 0; i < 11; i++) r[10 + i] = pp[mirror_list[i]];
            end
            8'h04: r = pp[31:0];
            8'h08: r = pp[63:32];
            8'h0C: r = {24'h0, fe, fs};
            8'h10: r = pm[31:0];
            8'h14: r = pm[63:32];
            8'h18: r = {24'h0, lm};
            8'h1C: r = ~pm[31:0];
            8'h20: r = ~pm[63:32];
            8'h24: r = ~{24'h0, lm};
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic exp_irq();
        return (|(pl & pm)) || (|(ll & lm));
    endfunction

    function automatic logic exp_fiq();
        if (!fe) return 1'b0;
        if (fs < 7'd64) return pl[fs[5:0]];
        if (fs < 7'd72) return ll[3'(fs - 7'd64)];
        return 1'b0;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h0C: begin fs = d[6:0]; fe = d[7]; end
            8'h10: pm[31:0]  = pm[31:0] | d;
            8'h14: pm[63:32] = pm[63:32] | d;
            8'h18: lm = lm | d[7:0];
            8'h1C: pm[31:0]  = pm[31:0] & ~d;
            8'h20: pm[63:32] = pm[63:32] & ~d;
            8'h24: lm = lm & ~d[7:0];
            default: ;
        endcase
    endtask

    // Driver: one write, ends on the negedge after the capturing edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        q.push_back(it);
    endtask

    task automatic chk_out(input string tag);
        push(1, 32'(exp_irq()), {tag, " irq_o"});
        push(2, 32'(exp_fiq()), {tag, " fiq_o"});
    endtask

    task automatic chk_reg(input logic [7:0] a, input string tag);
        @(negedge clk);
        bus_addr = a;
        push(0, exp_reg(a), $sformatf("%s rd@%02h", tag, a));
    endtask

    task automatic sweep(input string tag);
        logic [7:0] addrs [11] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                                   8'h18, 8'h1C, 8'h20, 8'h24, 8'h28};
        for (int i = 0; i < 11; i++) chk_reg(addrs[i], tag);
    endtask

    // Let the registered outputs catch up, then check them.
    task automatic settle_out(input string tag);
        @(negedge clk);
        chk_out(tag);
    endtask

    // Monitor: compares queued expectations just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    0:       act = bus_rdata;
                    1:       act = 32'(irq_o);
                    default: act = 32'(fiq_o);
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk_out("R1 reset");
        sweep("R1 R4 reset");

        // R10: a high line with a clear mask bit stays silent
        @(negedge clk);
        pl = 64'h8;
        settle_out("R10 unmasked ignored");
        chk_reg(8'h04, "R5 masked off");

        // R10 R5 R6: enable line 3
        wr(8'h10, 32'h0000_0008);
        settle_out("R10 enabled line");
        chk_reg(8'h04, "R5 pending low");
        chk_reg(8'h00, "R6 bank flag");

        // R2: set is an OR
        wr(8'h10, 32'h0000_0010);
        chk_reg(8'h10, "R2 or merge");

        // R3 R4: clear removes only bits written as one
        wr(8'h1C, 32'h0000_0008);
        chk_reg(8'h10, "R3 clear low");
        chk_reg(8'h1C, "R4 inverse low");
        settle_out("R3 irq drops");

        // R5: no latching
        @(negedge clk);
        pl = 64'h10;
        settle_out("R5 line high");
        chk_reg(8'h04, "R5 follows level");
        @(negedge clk);
        pl = '0;
        settle_out("R5 line dropped");
        chk_reg(8'h04, "R5 no latch");

        // R7: walk the mirrored lines, R6 high bank flag
        wr(8'h10, 32'h000C_0680);
        wr(8'h14, 32'h43E0_0100);
        chk_reg(8'h14, "R2 set high");
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            pl = 64'h1 << mirror_list[i];
            chk_reg(8'h00, $sformatf("R7 mirror %0d", i));
        end
        @(negedge clk);
        pl = 64'h1 << 40;
        chk_reg(8'h00, "R6 high bank only");
        chk_reg(8'h08, "R5 pending high");
        @(negedge clk);
        pl = 64'h1 << 11;
        chk_reg(8'h00, "R7 unmirrored masked off");

        // R2 R4: local group uses only the low byte
        wr(8'h18, 32'hFFFF_FF05);
        chk_reg(8'h18, "R2 local low byte");
        chk_reg(8'h24, "R4 local inverse");
        @(negedge clk);
        pl = '0;
        ll = 8'h07;
        settle_out("R10 local line");
        chk_reg(8'h00, "R6 local bits");
        wr(8'h24, 32'hFFFF_FF01);
        chk_reg(8'h18, "R3 local clear");
        chk_reg(8'h00, "R6 after local clear");

        // R9: fast path ignores masks
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        chk_reg(8'h24, "R3 local all clear");
        @(negedge clk);
        ll = 8'h40;
        wr(8'h0C, 32'h0000_00C6);
        settle_out("R9 local fast unmasked");
        chk_reg(8'h0C, "R8 readback");
        wr(8'h0C, 32'hFFFF_FF85);
        chk_reg(8'h0C, "R8 upper bits dropped");
        @(negedge clk);
        pl = 64'h20;
        settle_out("R8 periph select");
        @(negedge clk);
        pl = '1;
        ll = '1;
        wr(8'h0C, 32'h0000_00C8);
        settle_out("R9 select 72");
        wr(8'h0C, 32'h0000_00FF);
        settle_out("R9 select 127");
        wr(8'h0C, 32'h0000_0047);
        settle_out("R9 local select 71");
        wr(8'h0C, 32'h0000_00C7);
        settle_out("R9 local select 71 enabled");
        wr(8'h0C, 32'h0000_0005);
        settle_out("R9 disabled");

        // R11: outputs move exactly one edge after an input change
        wr(8'h0C, 32'h0000_0085);
        wr(8'h10, 32'h0000_0020);
        @(negedge clk);
        pl = '0;
        ll = '0;
        settle_out("R11 quiet");
        @(negedge clk);
        chk_out("R11 before edge");
        pl = 64'h20;
        settle_out("R11 one edge");
        @(negedge clk);
        chk_out("R11 before fall");
        pl = '0;
        settle_out("R11 fall one edge");

        // R12: unmapped reads and ignored writes
        @(negedge clk);
        pl = 64'h0000_00FF_0000_0020;
        ll = 8'h3C;
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        sweep("R12 ignored writes");
        chk_reg(8'h80, "R12 unmapped read");
        settle_out("R12 outputs unchanged");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule